// File: doc/BRIEF.md
# Self-Clearing Reset Pulse Sequencer

This block is a single channel of a peripheral reset controller. Software writes a control word with the request bit set. The channel then gates the peripheral clock off and drives the peripheral reset high for a programmable number of timebase ticks. It drops reset while the clock stays gated for the same number of ticks, and waits one more tick before it turns the clock back on. When the clock comes back on, the channel clears the request bit itself and raises a sticky completion flag. Software clears that flag by writing a one to it.

Timing comes from a one-cycle `tick` strobe supplied from outside, with one strobe every 0.25 µs. The period field is 8 bits wide, so each phase lasts at most 255 ticks (63.75 µs) and a complete sequence lasts a little over twice that. The positions of the request, done and period fields in the control word are parameters, so each channel instance can match its own register layout.

Top module: `rst_pulse_seq`

## Requirements
- R1: After reset, `rd_data` reads all zeros, `periph_rst` is 0 and `periph_clk_en` is 1.
- R2: Writing the control word while idle with bit 0 (request) set starts a sequence. From the next cycle `periph_rst` is 1 and `periph_clk_en` is 0. Bit 0 of `rd_data` reads 1 for as long as the clock is gated.
- R3: The reset-applied phase lasts exactly max(P,1) ticks. P is bits [15:8] of the starting write, and a value of 0 counts as one tick.
- R4: When reset drops, the clock stays gated. Exactly max(P,1)+1 ticks then pass with `periph_rst` 0 and `periph_clk_en` 0, and the clock enable returns high after the last of them.
- R5: `periph_rst` is never 1 while `periph_clk_en` is 1.
- R6: In the cycle the clock enable returns high, bit 0 of `rd_data` reads 0 and the done flag (bit 31) reads 1.
- R7: The done flag holds until a write with bit 31 set. Writes with bit 31 clear leave it unchanged.
- R8: If a write that clears the done flag lands in the same cycle the sequence finishes, the flag still ends up set.
- R9: A request written while a sequence runs has no effect. The running sequence keeps its length and no second sequence follows.
- R10: Bits [15:8] of `rd_data` return the period field from the most recent write.
- R11: Ticks that arrive while idle leave `periph_rst` at 0 and `periph_clk_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe, one per 0.25 µs |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word: request bit 0, period [15:8], done clear bit 31 |
| rd_data | output | 32 | Status: busy request bit 0, period [15:8], done bit 31 |
| periph_rst | output | 1 | Active-high reset to the peripheral |
| periph_clk_en | output | 1 | Enable for the peripheral clock gate |

## Verification
The hardest case to reach from the ports is a clear of the done flag that lands in exactly the cycle the sequence finishes. To hit it, the bench stops the free-running tick generator and issues the ticks itself, one per cycle. It counts out both phases and the final restart tick, then puts the clear write in the same cycle as that last tick. The phase lengths are measured by counting the ticks seen while the reset output and the clock enable are in each state. This makes the expected counts independent of how the ticks line up with the write.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_APPLY  = 2'd1,
    PH_REMOVE = 2'd2,
    PH_RESUME = 2'd3
  } phase_e;

  function automatic logic phase_gates_clock(input phase_e ph);
    return ph != PH_IDLE;
  endfunction

  function automatic logic phase_holds_reset(input phase_e ph);
    return ph == PH_APPLY;
  endfunction

endpackage

// File: rtl/rps_tick_timer.sv
module rps_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] eff_units(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= eff_units(load_val);
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire = tick && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/rps_seq_fsm.sv
module rps_seq_fsm
  import rps_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PER_W-1:0] start_period,
  input  logic             expire,
  output phase_e           phase,
  output logic             load,
  output logic [PER_W-1:0] load_val,
  output logic             finish
);

  phase_e           phase_q, phase_d;
  logic [PER_W-1:0] run_period_q;
  logic             go;

  assign go    = start && (phase_q == PH_IDLE);
  assign phase = phase_q;

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = run_period_q;
    finish   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (go) begin
          phase_d  = PH_APPLY;
          load     = 1'b1;
          load_val = start_period;
        end
      end
      PH_APPLY: begin
        if (expire) begin
          phase_d  = PH_REMOVE;
          load     = 1'b1;
          load_val = run_period_q;
        end
      end
      PH_REMOVE: begin
        if (expire) begin
          phase_d  = PH_RESUME;
          load     = 1'b1;
          load_val = '0;
        end
      end
      PH_RESUME: begin
        if (expire) begin
          phase_d = PH_IDLE;
          finish  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      run_period_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (go) begin
        run_period_q <= start_period;
      end
    end
  end

endmodule

// File: rtl/rps_ctrl_regs.sv
module rps_ctrl_regs #(
  parameter int DATA_W   = 32,
  parameter int REQ_BIT  = 0,
  parameter int DONE_BIT = 31,
  parameter int PER_LSB  = 8,
  parameter int PER_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              finish,
  output logic              start,
  output logic [PER_W-1:0]  wr_period,
  output logic [DATA_W-1:0] rd_data
);

  logic [PER_W-1:0] period_q;
  logic             done_q;
  logic             clr_done;

  assign wr_period = wr_data[PER_LSB +: PER_W];
  assign start     = wr_en && wr_data[REQ_BIT] && !busy;
  assign clr_done  = wr_en && wr_data[DONE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        period_q <= wr_period;
      end
      if (finish) begin
        done_q <= 1'b1;
      end else if (clr_done) begin
        done_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[PER_LSB +: PER_W]  = period_q;
    rd_data[REQ_BIT]           = busy;
    rd_data[DONE_BIT]          = done_q;
  end

endmodule

// File: rtl/rst_pulse_seq.sv
module rst_pulse_seq
  import rps_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int REQ_BIT  = 0,
  parameter int DONE_BIT = 31,
  parameter int PER_LSB  = 8,
  parameter int PER_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              periph_rst,
  output logic              periph_clk_en
);

  phase_e           phase;
  logic             seq_start;
  logic             seq_finish;
  logic             seq_busy;
  logic             tmr_load;
  logic             tmr_expire;
  logic [PER_W-1:0] tmr_load_val;
  logic [PER_W-1:0] wr_period;

  assign seq_busy = phase_gates_clock(phase);

  rps_ctrl_regs #(
    .DATA_W  (DATA_W),
    .REQ_BIT (REQ_BIT),
    .DONE_BIT(DONE_BIT),
    .PER_LSB (PER_LSB),
    .PER_W   (PER_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .busy     (seq_busy),
    .finish   (seq_finish),
    .start    (seq_start),
    .wr_period(wr_period),
    .rd_data  (rd_data)
  );

  rps_seq_fsm #(
    .PER_W(PER_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (seq_start),
    .start_period(wr_period),
    .expire      (tmr_expire),
    .phase       (phase),
    .load        (tmr_load),
    .load_val    (tmr_load_val),
    .finish      (seq_finish)
  );

  rps_tick_timer #(
    .CNT_W(PER_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (tmr_load),
    .load_val(tmr_load_val),
    .expire  (tmr_expire)
  );

  assign periph_rst    = phase_holds_reset(phase);
  assign periph_clk_en = !phase_gates_clock(phase);

endmodule

// File: rtl/rps_sva.sv
module rps_sva #(
  parameter int DATA_W   = 32,
  parameter int REQ_BIT  = 0,
  parameter int DONE_BIT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              periph_rst,
  input logic              periph_clk_en,
  input logic              seq_start,
  input logic              seq_finish
);

  AST_RST_GATES_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> !periph_clk_en); // R5

  AST_START_APPLIES_RST: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> (periph_rst && !periph_clk_en)); // R2

  AST_REQ_WHILE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_clk_en |-> rd_data[REQ_BIT]); // R2

  AST_REMOVE_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_rst) |-> !periph_clk_en); // R4

  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> (rd_data[DONE_BIT] && !rd_data[REQ_BIT] && periph_clk_en)); // R8

  AST_CLK_BACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_clk_en) |-> rd_data[DONE_BIT]); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[DONE_BIT] && !(wr_en && wr_data[DONE_BIT])) |=> rd_data[DONE_BIT]); // R7

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_rst) |-> $past(periph_clk_en)); // R9

endmodule

bind rst_pulse_seq rps_sva #(
  .DATA_W  (DATA_W),
  .REQ_BIT (REQ_BIT),
  .DONE_BIT(DONE_BIT)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .periph_rst   (periph_rst),
  .periph_clk_en(periph_clk_en),
  .seq_start    (seq_start),
  .seq_finish   (seq_finish)
);

// File: tb/sim_rst_pulse_seq.sv
`timescale 1ns/1ps
module sim_rst_pulse_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        periph_rst;
  logic        periph_clk_en;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;

  always #4 clk = ~clk;

  rst_pulse_seq u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .periph_rst   (periph_rst),
    .periph_clk_en(periph_clk_en)
  );

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 190000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d cycles exp<190000", cyc_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_done();
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h8000_0000;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk("R7 done cleared by W1C", {31'd0, rd_data[31]}, 32'd0);
  endtask

  task automatic run_seq(input int p, input int div, input bit extra);
    int na = 0;
    int nr = 0;
    int k = 0;
    int cyc = 0;
    bit req_bad = 1'b0;
    bit excl_bad = 1'b0;
    int eff = (p == 0) ? 1 : p;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b1; wr_data = (32'(p) << 8) | 32'd1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk("R2 reset applied after request", {30'd0, periph_rst, periph_clk_en}, 32'b10);
    while (!periph_clk_en && cyc < 4000) begin
      if (!rd_data[0]) req_bad = 1'b1;
      if (periph_rst && periph_clk_en) excl_bad = 1'b1;
      tick = ((k % div) == div - 1);
      k++;
      if (tick && periph_rst) na++;
      if (tick && !periph_rst) nr++;
      wr_en = 1'b0; wr_data = '0;
      if (extra && cyc == 3) begin
        wr_en = 1'b1; wr_data = 32'h0000_0701;
      end
      cyc++;
      @(negedge clk);
    end
    tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R3 applied-phase ticks", 32'(na), 32'(eff));
    chk("R4 removed-phase ticks", 32'(nr), 32'(eff + 1));
    chk("R2 request reads busy", {31'd0, req_bad}, 32'd0);
    chk("R5 reset only with clock off", {31'd0, excl_bad}, 32'd0);
    chk("R6 request self-cleared, done set", {30'd0, rd_data[31], rd_data[0]}, 32'b10);
    chk("R10 period readback", {24'd0, rd_data[15:8]}, extra ? 32'd7 : 32'(p));
    if (extra) begin
      repeat (6) begin
        @(negedge clk);
        tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
      chk("R9 no second sequence", {30'd0, periph_rst, periph_clk_en}, 32'b01);
    end
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'(p) << 8;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk("R7 done holds on write of 0", {31'd0, rd_data[31]}, 32'd1);
    clear_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset readback", rd_data, 32'd0);
    chk("R1 reset outputs", {30'd0, periph_rst, periph_clk_en}, 32'b01);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: idle ticks
    for (int i = 0; i < 10; i++) begin
      tick = 1'b1;
      @(negedge clk);
      chk("R11 idle tick no effect", {30'd0, periph_rst, periph_clk_en}, 32'b01);
    end
    tick = 1'b0;

    // R10: period write without request
    wr_en = 1'b1; wr_data = 32'h0000_A500;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk("R10 period field stored", rd_data, 32'h0000_A500);
    chk("R10 no start without request", {31'd0, periph_clk_en}, 32'd1);

    // R3 R4 sweep
    for (int p = 0; p <= 12; p++) begin
      run_seq(p, 2, 1'b0);
      run_seq(p, 1, 1'b0);
    end
    run_seq(3, 3, 1'b0);
    run_seq(127, 2, 1'b0);
    run_seq(128, 1, 1'b0);
    run_seq(255, 2, 1'b0);

    // R9: request during a sequence
    run_seq(6, 2, 1'b1);
    run_seq(20, 1, 1'b1);

    // R8: clear collides with the finishing tick, period 2
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_0201;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    tick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 reset drops after two ticks", {30'd0, periph_rst, periph_clk_en}, 32'b00);
    @(negedge clk);
    @(negedge clk);
    chk("R4 clock still off before last tick", {31'd0, periph_clk_en}, 32'd0);
    wr_en = 1'b1; wr_data = 32'h8000_0000;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R8 set wins over clear", {30'd0, periph_clk_en, rd_data[31]}, 32'b11);
    clear_done();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule